// File: doc/BRIEF.md
# DMA Request FIFO Gateway

This block is a word queue that bridges a host register port and a set of DMA-controller consumers. The host arms a transfer through a small control register and loads a word count into a length register. It then streams data words into a data register. While the queue holds at least one word, every consumer sees its request line high, and any consumer may pop the oldest word, which appears on a shared read register.

The gateway protects itself against misuse. Writes that arrive while it is not armed, or while the queue is full, are dropped and recorded in a sticky missed-write flag. The length count disarms the transfer by itself after the last expected word, and the words already queued stay there to drain. When the host clears the armed bit itself, the queue is flushed and the request lines fall. Register select encoding on `hw_sel`: 0 is control, 1 is length, 2 is data, and 3 writes nothing.

Top module: `wordq_dma_gate`

## Requirements
- R1: After reset, all request lines, `armed_o`, `tgt_vram_o`, `tgt_dma_o` and `missed_o` are 0, and `len_left_o` and `rd_data_o` are 0.
- R2: A control write (`hw_sel`=0) with byte lane 0 enabled (`hw_be[0]`=1) loads the target flags and the armed bit: `hw_wdata[0]` goes to `tgt_vram_o`, `hw_wdata[1]` to `tgt_dma_o` and `hw_wdata[2]` to `armed_o`. A control write with `hw_be[0]`=0 changes nothing.
- R3: A length write (`hw_sel`=1, any lane enabled) loads `hw_wdata[LEN_W-1:0]` into the count. Each accepted data word lowers the count by one. The word that takes the count from 1 to 0 clears `armed_o`, and the queued words are kept. A count of 0 at arming allows 2^LEN_W words.
- R4: A data write (`hw_sel`=2) is accepted only while armed and the queue holds fewer than DEPTH words. Otherwise the queue and the count stay unchanged.
- R5: A data write with either byte lane enabled stores the whole `hw_wdata` word. A data write with no lane enabled is no write at all.
- R6: `missed_o` is set by every discarded data write. It stays set until a control write with lane 0 enabled clears it.
- R7: A control write that takes `armed_o` from 1 to 0 empties the queue. All request lines are low in the next cycle. A pop in that same cycle is ignored.
- R8: Every request line equals "queue not empty" and changes in the cycle after the push or pop that changes it.
- R9: A pop (any `pop_i` bit high) on a non-empty queue puts the oldest word on `rd_data_o` in the next cycle and removes exactly one word, however many consumers pop together. A pop on an empty queue leaves `rd_data_o` unchanged.
- R10: The queue is first-in first-out with DEPTH words of storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_en | input | 1 | Host write strobe |
| hw_sel | input | 2 | Register select: 0 control, 1 length, 2 data |
| hw_be | input | 2 | Byte-lane enables |
| hw_wdata | input | DATA_W | Host write data |
| pop_i | input | N_CONS | One pop strobe per consumer |
| dma_req_o | output | N_CONS | Request line per consumer |
| rd_data_o | output | DATA_W | Last popped word |
| armed_o | output | 1 | Transfer armed |
| tgt_vram_o | output | 1 | VRAM target flag |
| tgt_dma_o | output | 1 | DMA target flag |
| len_left_o | output | LEN_W | Words still expected |
| missed_o | output | 1 | Sticky missed-write flag |

## Verification
The bench builds the gateway with DEPTH=4, LEN_W=6, DATA_W=16 and two consumers. The shallow queue makes the full-queue rejection reachable within five writes. The 6-bit count lets a zero length wrap to 60 after four accepted words, which exercises the 2^LEN_W meaning of a zero count. The two consumers allow a simultaneous pop to be checked for removing a single word.

// File: rtl/gw_pkg.sv
package gw_pkg;
   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_LEN  = 2'd1,
      SEL_DATA = 2'd2,
      SEL_NONE = 2'd3
   } gw_sel_e;

   localparam int CTL_VRAM_BIT  = 0;
   localparam int CTL_DMA_BIT   = 1;
   localparam int CTL_ARMED_BIT = 2;

   typedef struct packed {
      logic armed;
      logic dma;
      logic vram;
   } gw_ctrl_t;
endpackage

// File: rtl/gw_ctrl.sv
module gw_ctrl
   import gw_pkg::*;
#(
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_wr,
   input  logic [2:0]       ctrl_bits,
   input  logic             len_wr,
   input  logic [LEN_W-1:0] len_val,
   input  logic             data_wr,
   input  logic             fifo_full,
   output gw_ctrl_t         ctrl_q,
   output logic [LEN_W-1:0] len_q,
   output logic             accept,
   output logic             flush,
   output logic             missed_q
);
   logic last_word;

   assign accept    = data_wr && ctrl_q.armed && !fifo_full;
   assign flush     = ctrl_wr && ctrl_q.armed && !ctrl_bits[CTL_ARMED_BIT];
   assign last_word = accept && (len_q == LEN_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_wr) begin
         ctrl_q.vram  <= ctrl_bits[CTL_VRAM_BIT];
         ctrl_q.dma   <= ctrl_bits[CTL_DMA_BIT];
         ctrl_q.armed <= ctrl_bits[CTL_ARMED_BIT];
      end else if (last_word) begin
         ctrl_q.armed <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_q <= '0;
      end else if (len_wr) begin
         len_q <= len_val;
      end else if (accept) begin
         len_q <= len_q - LEN_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         missed_q <= 1'b0;
      end else if (ctrl_wr) begin
         missed_q <= 1'b0;
      end else if (data_wr && !accept) begin
         missed_q <= 1'b1;
      end
   end
endmodule

// File: rtl/gw_fifo.sv
module gw_fifo #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 8,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   input  logic              flush,
   output logic [DATA_W-1:0] head,
   output logic              full,
   output logic              empty,
   output logic [CW-1:0]     level
);
   localparam bit POW2 = ((1 << AW) == DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wp, rp, wp_nx, rp_nx;
   logic              do_push, do_pop;

   generate
      if (POW2) begin : g_wrap_free
         assign wp_nx = wp + AW'(1);
         assign rp_nx = rp + AW'(1);
      end else begin : g_wrap_cmp
         assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
         assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      end
   endgenerate

   assign full    = (level == CW'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign head    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         if (do_push) wp <= wp_nx;
         if (do_pop)  rp <= rp_nx;
         case ({do_push, do_pop})
            2'b10:   level <= level + CW'(1);
            2'b01:   level <= level - CW'(1);
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/gw_readout.sv
module gw_readout #(
   parameter int DATA_W = 16,
   parameter int N_CONS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_CONS-1:0] pop_vec,
   input  logic              empty,
   input  logic              flush,
   input  logic [DATA_W-1:0] head,
   output logic              take,
   output logic [N_CONS-1:0] req,
   output logic [DATA_W-1:0] rd_data
);
   assign take = (|pop_vec) && !empty && !flush;

   generate
      for (genvar g = 0; g < N_CONS; g++) begin : g_req
         assign req[g] = !empty;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    rd_data <= '0;
      else if (take) rd_data <= head;
   end
endmodule

// File: rtl/wordq_dma_gate.sv
module wordq_dma_gate
   import gw_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 8,
   parameter int LEN_W  = 16,
   parameter int N_CONS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_en,
   input  logic [1:0]        hw_sel,
   input  logic [1:0]        hw_be,
   input  logic [DATA_W-1:0] hw_wdata,
   input  logic [N_CONS-1:0] pop_i,
   output logic [N_CONS-1:0] dma_req_o,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              armed_o,
   output logic              tgt_vram_o,
   output logic              tgt_dma_o,
   output logic [LEN_W-1:0]  len_left_o,
   output logic              missed_o
);
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DATA_W < 8)      begin : g_bad_width $error("DATA_W must cover the control byte"); end
      if (DEPTH < 2)       begin : g_bad_depth $error("DEPTH must be at least 2"); end
      if (LEN_W < 1)       begin : g_bad_len   $error("LEN_W must be at least 1"); end
      if (LEN_W > DATA_W)  begin : g_len_wide  $error("LEN_W must not exceed DATA_W"); end
      if (N_CONS < 1)      begin : g_bad_cons  $error("N_CONS must be at least 1"); end
   endgenerate

   gw_sel_e           sel;
   logic              ctrl_wr, len_wr, data_wr;
   gw_ctrl_t          ctrl_q;
   logic              accept, flush, take;
   logic              fifo_full, fifo_empty;
   logic [DATA_W-1:0] fifo_head;
   logic [CW-1:0]     fifo_level;

   assign sel     = gw_sel_e'(hw_sel);
   assign ctrl_wr = hw_en && (sel == SEL_CTRL) && hw_be[0];
   assign len_wr  = hw_en && (sel == SEL_LEN)  && (|hw_be);
   assign data_wr = hw_en && (sel == SEL_DATA) && (|hw_be);

   gw_ctrl #(.LEN_W(LEN_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_wr   (ctrl_wr),
      .ctrl_bits (hw_wdata[2:0]),
      .len_wr    (len_wr),
      .len_val   (hw_wdata[LEN_W-1:0]),
      .data_wr   (data_wr),
      .fifo_full (fifo_full),
      .ctrl_q    (ctrl_q),
      .len_q     (len_left_o),
      .accept    (accept),
      .flush     (flush),
      .missed_q  (missed_o)
   );

   gw_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (accept),
      .push_data (hw_wdata),
      .pop       (take),
      .flush     (flush),
      .head      (fifo_head),
      .full      (fifo_full),
      .empty     (fifo_empty),
      .level     (fifo_level)
   );

   gw_readout #(.DATA_W(DATA_W), .N_CONS(N_CONS)) u_read (
      .clk     (clk),
      .rst_n   (rst_n),
      .pop_vec (pop_i),
      .empty   (fifo_empty),
      .flush   (flush),
      .head    (fifo_head),
      .take    (take),
      .req     (dma_req_o),
      .rd_data (rd_data_o)
   );

   assign armed_o    = ctrl_q.armed;
   assign tgt_vram_o = ctrl_q.vram;
   assign tgt_dma_o  = ctrl_q.dma;
endmodule

// File: rtl/gw_chk.sv
module gw_chk #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 8,
   parameter int LEN_W  = 16,
   parameter int N_CONS = 2,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hw_en,
   input logic [1:0]        hw_sel,
   input logic [1:0]        hw_be,
   input logic [DATA_W-1:0] hw_wdata,
   input logic [N_CONS-1:0] pop_i,
   input logic [N_CONS-1:0] req,
   input logic [DATA_W-1:0] rd_data,
   input logic              armed,
   input logic [LEN_W-1:0]  len_left,
   input logic              missed,
   input logic [CW-1:0]     level
);
   logic c_ctrl, c_data;
   assign c_ctrl = hw_en && (hw_sel == 2'd0) && hw_be[0];
   assign c_data = hw_en && (hw_sel == 2'd2) && (|hw_be);

   // R10
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CW'(DEPTH));

   // R4
   reject_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (c_data && !armed) |=> $stable(len_left));

   // R6
   missed_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (c_data && !armed) |=> missed);

   // R6
   missed_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c_ctrl |=> !missed);

   // R7
   flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (c_ctrl && armed && !hw_wdata[2]) |=> (level == '0 && !req[0]));

   // R3
   auto_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (c_data && armed && len_left == LEN_W'(1) && level < CW'(DEPTH)) |=> !armed);

   // R8
   req_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (c_data && armed && level < CW'(DEPTH)) |=> req[N_CONS-1]);

   // R9
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i == '0) |=> $stable(rd_data));
endmodule

bind wordq_dma_gate gw_chk #(
   .DATA_W(DATA_W), .DEPTH(DEPTH), .LEN_W(LEN_W), .N_CONS(N_CONS)
) u_gw_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .hw_en    (hw_en),
   .hw_sel   (hw_sel),
   .hw_be    (hw_be),
   .hw_wdata (hw_wdata),
   .pop_i    (pop_i),
   .req      (dma_req_o),
   .rd_data  (rd_data_o),
   .armed    (armed_o),
   .len_left (len_left_o),
   .missed   (missed_o),
   .level    (fifo_level)
);

// File: tb/tb_wordq_dma_gate.sv
`timescale 1ns/1ps
module tb_wordq_dma_gate;
   localparam int DATA_W = 16;
   localparam int DEPTH  = 4;
   localparam int LEN_W  = 6;
   localparam int N_CONS = 2;
   localparam int NV     = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              hw_en = 1'b0;
   logic [1:0]        hw_sel = '0;
   logic [1:0]        hw_be = '0;
   logic [DATA_W-1:0] hw_wdata = '0;
   logic [N_CONS-1:0] pop_i = '0;
   logic [N_CONS-1:0] dma_req_o;
   logic [DATA_W-1:0] rd_data_o;
   logic              armed_o, tgt_vram_o, tgt_dma_o, missed_o;
   logic [LEN_W-1:0]  len_left_o;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #2 clk = ~clk;

   wordq_dma_gate #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LEN_W(LEN_W), .N_CONS(N_CONS)) dut (
      .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .hw_sel(hw_sel), .hw_be(hw_be),
      .hw_wdata(hw_wdata), .pop_i(pop_i), .dma_req_o(dma_req_o), .rd_data_o(rd_data_o),
      .armed_o(armed_o), .tgt_vram_o(tgt_vram_o), .tgt_dma_o(tgt_dma_o),
      .len_left_o(len_left_o), .missed_o(missed_o)
   );

   // entry: tag[49:46] op[45] sel[44:43] be/pop[42:41] data[40:25]
   //        req[24] armed[23] missed[22] len[21:16] rd[15:0]
   localparam logic [49:0] TBL [NV] = '{
      {4'd3,  1'b0, 2'd1, 2'b11, 16'h0005, 1'b0, 1'b0, 1'b0, 6'd5, 16'h0000}, // R3 load length
      {4'd2,  1'b0, 2'd0, 2'b01, 16'h0007, 1'b0, 1'b1, 1'b0, 6'd5, 16'h0000}, // R2 arm
      {4'd5,  1'b0, 2'd2, 2'b11, 16'h1111, 1'b1, 1'b1, 1'b0, 6'd4, 16'h0000}, // R5 both lanes
      {4'd5,  1'b0, 2'd2, 2'b01, 16'h2222, 1'b1, 1'b1, 1'b0, 6'd3, 16'h0000}, // R5 low lane only
      {4'd5,  1'b0, 2'd2, 2'b10, 16'h3333, 1'b1, 1'b1, 1'b0, 6'd2, 16'h0000}, // R5 high lane only
      {4'd9,  1'b1, 2'd0, 2'b01, 16'h0000, 1'b1, 1'b1, 1'b0, 6'd2, 16'h1111}, // R9 pop
      {4'd4,  1'b0, 2'd2, 2'b11, 16'h4444, 1'b1, 1'b1, 1'b0, 6'd1, 16'h1111}, // R4 accepted
      {4'd3,  1'b0, 2'd2, 2'b11, 16'h5555, 1'b1, 1'b0, 1'b0, 6'd0, 16'h1111}, // R3 auto disarm
      {4'd6,  1'b0, 2'd2, 2'b11, 16'h6666, 1'b1, 1'b0, 1'b1, 6'd0, 16'h1111}, // R6 missed write
      {4'd10, 1'b1, 2'd0, 2'b10, 16'h0000, 1'b1, 1'b0, 1'b1, 6'd0, 16'h2222}, // R10 order
      {4'd10, 1'b1, 2'd0, 2'b01, 16'h0000, 1'b1, 1'b0, 1'b1, 6'd0, 16'h3333}, // R10 order
      {4'd10, 1'b1, 2'd0, 2'b10, 16'h0000, 1'b1, 1'b0, 1'b1, 6'd0, 16'h4444}, // R10 order
      {4'd8,  1'b1, 2'd0, 2'b01, 16'h0000, 1'b0, 1'b0, 1'b1, 6'd0, 16'h5555}, // R8 drained
      {4'd9,  1'b1, 2'd0, 2'b11, 16'h0000, 1'b0, 1'b0, 1'b1, 6'd0, 16'h5555}, // R9 empty pop
      {4'd6,  1'b0, 2'd0, 2'b01, 16'h0004, 1'b0, 1'b1, 1'b0, 6'd0, 16'h5555}, // R6 clear on ctrl
      {4'd2,  1'b0, 2'd0, 2'b10, 16'h0000, 1'b0, 1'b1, 1'b0, 6'd0, 16'h5555}  // R2 high lane ignored
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic hwrite(input logic [1:0] s, input logic [1:0] b, input logic [15:0] d);
      @(negedge clk);
      hw_en = 1'b1; hw_sel = s; hw_be = b; hw_wdata = d;
      @(negedge clk);
      hw_en = 1'b0; hw_be = '0;
   endtask

   task automatic cpop(input logic [1:0] p);
      @(negedge clk);
      pop_i = p;
      @(negedge clk);
      pop_i = '0;
   endtask

   function automatic logic [63:0] snap();
      return {38'd0, dma_req_o[1], dma_req_o[0], armed_o, missed_o, len_left_o, rd_data_o};
   endfunction

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 reset", {55'd0, dma_req_o, armed_o, tgt_vram_o, tgt_dma_o, missed_o, len_left_o[0]}, 64'd0);
      chk("R1 reset rd", {48'd0, rd_data_o}, 64'd0);

      for (int i = 0; i < NV; i++) begin
         logic [49:0] e;
         e = TBL[i];
         if (e[45]) cpop(e[42:41]);
         else       hwrite(e[44:43], e[42:41], e[40:25]);
         chk($sformatf("R%0d row %0d", e[49:46], i), snap(),
             {38'd0, e[24], e[24], e[23], e[22], e[21:16], e[15:0]});
      end

      // R2 target flags
      hwrite(2'd0, 2'b01, 16'h0005);
      chk("R2 flags", {61'd0, tgt_vram_o, tgt_dma_o, armed_o}, 64'b101);

      // R5 no lane enabled writes nothing
      hwrite(2'd2, 2'b00, 16'hAAAA);
      chk("R5 no lane", snap(), {38'd0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd0, 16'h5555});

      // R4 fill to DEPTH, zero count wraps (R3)
      for (int k = 0; k < DEPTH; k++) hwrite(2'd2, 2'b11, 16'hA0A0 + 16'(k));
      chk("R3 wrap count", {58'd0, len_left_o}, 64'd60);
      hwrite(2'd2, 2'b11, 16'hAFAF);
      chk("R4 full reject", {57'd0, missed_o, len_left_o}, {57'd0, 1'b1, 6'd60});
      cpop(2'b01);
      chk("R10 head after full", {48'd0, rd_data_o}, 64'hA0A0);

      // R7 disarm flushes
      hwrite(2'd0, 2'b01, 16'h0000);
      chk("R7 flush req", {61'd0, dma_req_o, armed_o}, 64'd0);
      cpop(2'b11);
      chk("R7 empty after flush", {48'd0, rd_data_o}, 64'hA0A0);

      // R9 dual pop removes one word
      hwrite(2'd0, 2'b01, 16'h0004);
      hwrite(2'd1, 2'b11, 16'h0002);
      hwrite(2'd2, 2'b11, 16'hB0B0);
      hwrite(2'd2, 2'b11, 16'hB1B1);
      chk("R3 disarm after count", {63'd0, armed_o}, 64'd0);
      cpop(2'b11);
      chk("R9 dual pop", {46'd0, dma_req_o, rd_data_o}, {46'd0, 2'b11, 16'hB0B0});
      cpop(2'b10);
      chk("R8 req drop", {46'd0, dma_req_o, rd_data_o}, {46'd0, 2'b00, 16'hB1B1});

      // R1 reset mid-run
      hwrite(2'd0, 2'b01, 16'h0007);
      hwrite(2'd2, 2'b11, 16'hC0C0);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      chk("R1 rerun reset", {48'd0, dma_req_o, armed_o, tgt_vram_o, tgt_dma_o, missed_o, len_left_o, 4'd0},
          {48'd0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 4'd0});

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule